// File: doc/BRIEF.md
# Address-Latch Multicart PRG Bank Mapper

This block is the banking controller of a multi-game cartridge on an 8-bit console CPU bus. When the CPU writes anywhere in the upper half of its address space ($8000-$FFFF), the block stores the low eleven bits of the write *address* in a mode register. The data value plays no part. The register then selects how the two 16 KiB CPU windows ($8000-$BFFF and $C000-$FFFF) map into a 1 MiB PRG-ROM.

From the mode register the block derives the following outputs:
- the full 20-bit PRG-ROM address;
- a PRG-ROM output enable;
- the nametable address line for horizontal or vertical mirroring;
- a CHR-RAM write enable, which can be blocked in the fixed-32K and mirrored-16K modes.

Three banking modes are available:
- a switchable window with a fixed first or fixed last bank;
- a 16 KiB bank mirrored into both windows;
- a 32 KiB bank.

A menu-select mode replaces the lowest four PRG address bits with four solder-pad inputs. Two parameters choose the board variant: one enables the solder-pad mode, the other enables CHR-RAM write protection.

Top module: `latch_bank_mapper`

## Requirements
- R1: A cycle with `cpu_wr_stb`=1 and `cpu_addr[15]`=1 loads `cpu_addr[10:0]` into the mode register at that clock edge. Any strobe with `cpu_addr[15]`=0 leaves the mode register, and so every output, unchanged.
- R2: The register fields are: bit 0 = A14 pass, bit 1 = mirroring, bits 4..2 = inner bank (bit 2 = low bit "p"), bits 8,6,5 = outer bank, bit 7 = NROM, bit 9 = fixed-last, bit 10 = pad select. While bit 0 is 1, `prg_addr[14]` in a switchable window equals `cpu_addr[14]`. While bit 0 is 0, it equals register bit 2.
- R3: When register bit 1 is 0, `ciram_a10` follows `ppu_a10` (vertical mirroring). When bit 1 is 1, it follows `ppu_a11` (horizontal mirroring).
- R4: `prg_addr[19:17]` equals {reg[8], reg[6], reg[5]} in both windows. `prg_addr[13:4]` equals `cpu_addr[13:4]`.
- R5: With bit 7 = 1 and bit 0 = 0, both windows map to bank {reg[4:3], reg[2]}. With bit 7 = 1 and bit 0 = 1, `prg_addr[16:14]` = {reg[4:3], cpu_addr[14]}, which is a 32 KiB bank.
- R6: With bit 7 = 0, the $8000 window uses the switchable bank. The $C000 window uses inner bank 0 when bit 9 is 0 and inner bank 7 when bit 9 is 1.
- R7: With `PAD_SEL_EN`=1 and register bit 10 = 1, `prg_addr[3:0]` equals `pads`. Otherwise it equals `cpu_addr[3:0]`.
- R8: With `CHR_WP_EN`=1, `chr_we` is 0 while register bit 7 is 1 and equals `ppu_wr_stb` while bit 7 is 0. With `CHR_WP_EN`=0, `chr_we` always equals `ppu_wr_stb`.
- R9: Synchronous reset clears the mode register. After reset, both windows select inner bank 0 and outer bank 0.
- R10: `prg_oe` is 1 exactly when `cpu_rw`=1 (read) and `cpu_addr[15]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_wr_stb | input | 1 | Single-cycle write strobe, one per bus write |
| pads | input | 4 | Solder-pad menu-select value |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_wr_stb | input | 1 | PPU write strobe to CHR-RAM |
| prg_addr | output | 20 | PRG-ROM address |
| prg_oe | output | 1 | PRG-ROM output enable |
| ciram_a10 | output | 1 | Nametable address bit for mirroring |
| chr_we | output | 1 | CHR-RAM write enable |

## Verification
The bench uses the default variant: `PAD_SEL_EN`=1 and `CHR_WP_EN`=1. These values bring the solder-pad substitution of the low nibble and the blocking of CHR-RAM writes in both NROM modes within reach.

The bench writes mode words that cover every combination of the A14-pass, NROM and fixed-last bits. It uses several inner and outer banks, both mirroring settings and both pad-select settings. Every clock, it compares the PRG address of reads in both windows against a behavioural bank model.

The variant with both options at 0 is not built here. It differs only in the two gated terms.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int CPU_AW   = 16;
    localparam int PRG_AW   = 20;
    localparam int CFG_W    = 11;
    localparam int PAD_W    = 4;
    localparam int BANK_W   = 3;
    localparam int PASS_LSB = PAD_W;
    localparam int PASS_MSB = 13;

    typedef struct packed {
        logic       pad_sel;
        logic       last_fix;
        logic       outer_hi;
        logic       nrom;
        logic [1:0] outer_lo;
        logic [1:0] inner_hi;
        logic       inner_lo;
        logic       horiz;
        logic       a14_pass;
    } cfg_t;

    typedef enum logic [1:0] {
        MAP_FIXED_FIRST = 2'd0,
        MAP_FIXED_LAST  = 2'd1,
        MAP_NROM16      = 2'd2,
        MAP_NROM32      = 2'd3
    } map_mode_e;

    function automatic map_mode_e mode_of(cfg_t c);
        if (c.nrom) return c.a14_pass ? MAP_NROM32 : MAP_NROM16;
        return c.last_fix ? MAP_FIXED_LAST : MAP_FIXED_FIRST;
    endfunction

    function automatic logic [BANK_W-1:0] switch_bank(cfg_t c, logic a14);
        return {c.inner_hi, (c.a14_pass ? a14 : c.inner_lo)};
    endfunction

    function automatic logic [BANK_W-1:0] inner_bank(cfg_t c, logic a14);
        logic [BANK_W-1:0] b;
        unique case (mode_of(c))
            MAP_NROM16, MAP_NROM32: b = switch_bank(c, a14);
            MAP_FIXED_FIRST:        b = a14 ? '0 : switch_bank(c, a14);
            MAP_FIXED_LAST:         b = a14 ? '1 : switch_bank(c, a14);
            default:                b = '0;
        endcase
        return b;
    endfunction

    function automatic logic [BANK_W-1:0] outer_bank(cfg_t c);
        return {c.outer_hi, c.outer_lo};
    endfunction

endpackage

// File: rtl/lbm_mode_reg.sv
module lbm_mode_reg
    import lbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] addr_bits,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_t'(addr_bits);
        end
    end

endmodule

// File: rtl/lbm_prg_map.sv
module lbm_prg_map
    import lbm_pkg::*;
#(
    parameter bit PAD_SEL_EN = 1'b1
) (
    input  cfg_t              cfg,
    input  logic [14:0]       cpu_lo,
    input  logic [PAD_W-1:0]  pads,
    output logic [PRG_AW-1:0] prg_addr
);

    logic [BANK_W-1:0] inner_w;
    logic [BANK_W-1:0] outer_w;
    logic [PAD_W-1:0]  low_w;

    always_comb begin
        inner_w = inner_bank(cfg, cpu_lo[14]);
        outer_w = outer_bank(cfg);
    end

    generate
        if (PAD_SEL_EN) begin : g_pad
            always_comb low_w = cfg.pad_sel ? pads : cpu_lo[PAD_W-1:0];
        end else begin : g_nopad
            always_comb low_w = cpu_lo[PAD_W-1:0];
        end
    endgenerate

    always_comb begin
        prg_addr = {outer_w, inner_w, cpu_lo[PASS_MSB:PASS_LSB], low_w};
    end

endmodule

// File: rtl/lbm_ppu_side.sv
module lbm_ppu_side
    import lbm_pkg::*;
#(
    parameter bit CHR_WP_EN = 1'b1
) (
    input  cfg_t cfg,
    input  logic ppu_a10,
    input  logic ppu_a11,
    input  logic ppu_wr_stb,
    output logic ciram_a10,
    output logic chr_we
);

    always_comb ciram_a10 = cfg.horiz ? ppu_a11 : ppu_a10;

    generate
        if (CHR_WP_EN) begin : g_wp
            always_comb chr_we = ppu_wr_stb & ~cfg.nrom;
        end else begin : g_open
            always_comb chr_we = ppu_wr_stb;
        end
    endgenerate

endmodule

// File: rtl/latch_bank_mapper.sv
module latch_bank_mapper
    import lbm_pkg::*;
#(
    parameter bit PAD_SEL_EN = 1'b1,
    parameter bit CHR_WP_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_wr_stb,
    input  logic [PAD_W-1:0]  pads,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    input  logic              ppu_wr_stb,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_oe,
    output logic              ciram_a10,
    output logic              chr_we
);

    cfg_t cfg_q;
    logic cart_hit;
    logic reg_load;

    always_comb begin
        cart_hit = cpu_addr[CPU_AW-1];
        reg_load = cpu_wr_stb & cart_hit;
        prg_oe   = cpu_rw & cart_hit;
    end

    lbm_mode_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (reg_load),
        .addr_bits (cpu_addr[CFG_W-1:0]),
        .cfg_q     (cfg_q)
    );

    lbm_prg_map #(.PAD_SEL_EN(PAD_SEL_EN)) u_prg (
        .cfg      (cfg_q),
        .cpu_lo   (cpu_addr[14:0]),
        .pads     (pads),
        .prg_addr (prg_addr)
    );

    lbm_ppu_side #(.CHR_WP_EN(CHR_WP_EN)) u_ppu (
        .cfg        (cfg_q),
        .ppu_a10    (ppu_a10),
        .ppu_a11    (ppu_a11),
        .ppu_wr_stb (ppu_wr_stb),
        .ciram_a10  (ciram_a10),
        .chr_we     (chr_we)
    );

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker
    import lbm_pkg::*;
#(
    parameter bit CHR_WP_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_wr_stb,
    input logic              ppu_a10,
    input logic              ppu_a11,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              prg_oe,
    input logic              ciram_a10,
    input logic              chr_we,
    input cfg_t              cfg_q
);

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_stb && cpu_addr[15]) |=> (cfg_q == cfg_t'($past(cpu_addr[CFG_W-1:0])))); // R1

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr_stb && cpu_addr[15]) |=> $stable(cfg_q)); // R1

    AST_MIRROR_H: assert property (@(posedge clk) disable iff (rst)
        cfg_q.horiz |-> (ciram_a10 == ppu_a11)); // R3

    AST_MIRROR_V: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.horiz |-> (ciram_a10 == ppu_a10)); // R3

    AST_OUTER_BANK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (prg_addr[19:17] == {cfg_q.outer_hi, cfg_q.outer_lo})); // R4

    AST_NROM32_A14: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.nrom && cfg_q.a14_pass) |-> (prg_addr[14] == cpu_addr[14])); // R5

    AST_FIXED_LAST: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.nrom && cfg_q.last_fix && cpu_addr[14]) |-> (prg_addr[16:14] == 3'b111)); // R6

    AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.nrom && !cfg_q.last_fix && cpu_addr[14]) |-> (prg_addr[16:14] == 3'b000)); // R6

    AST_CHR_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (CHR_WP_EN && cfg_q.nrom) |-> !chr_we); // R8

    AST_RESET_BANK: assert property (@(posedge clk)
        rst |=> (prg_addr[19:14] == 6'd0)); // R9

    AST_OE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[15] || !cpu_rw) |-> !prg_oe); // R10

endmodule

bind latch_bank_mapper lbm_checker #(.CHR_WP_EN(CHR_WP_EN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .cpu_wr_stb (cpu_wr_stb),
    .ppu_a10    (ppu_a10),
    .ppu_a11    (ppu_a11),
    .prg_addr   (prg_addr),
    .prg_oe     (prg_oe),
    .ciram_a10  (ciram_a10),
    .chr_we     (chr_we),
    .cfg_q      (cfg_q)
);

// File: tb/latch_bank_mapper_test.sv
`timescale 1ns/1ps
module latch_bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic        cpu_wr_stb = 1'b0;
    logic [3:0]  pads = 4'h0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic        ppu_wr_stb = 1'b0;
    logic [19:0] prg_addr;
    logic        prg_oe;
    logic        ciram_a10;
    logic        chr_we;

    int n_tests = 0;
    int n_fail  = 0;
    int m_cfg   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    latch_bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wr_stb(cpu_wr_stb), .pads(pads), .ppu_a10(ppu_a10),
        .ppu_a11(ppu_a11), .ppu_wr_stb(ppu_wr_stb), .prg_addr(prg_addr),
        .prg_oe(prg_oe), .ciram_a10(ciram_a10), .chr_we(chr_we)
    );

    task automatic check(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (cfg %0h addr %0h)", tag, got, exp, m_cfg, cpu_addr);
        end
    endtask

    // behavioural reference: 16 KiB bank number per window
    function automatic int ref_inner(int c, int a);
        int pp = (c >> 3) & 3;
        int p  = (c >> 2) & 1;
        int s  = c & 1;
        int o  = (c >> 7) & 1;
        int l  = (c >> 9) & 1;
        int w  = (a >> 14) & 1;
        if (o == 1)      return pp * 2 + ((s == 1) ? w : p);
        else if (w == 0) return pp * 2 + ((s == 1) ? 0 : p);
        else             return (l == 1) ? 7 : 0;
    endfunction

    function automatic int ref_prg(int c, int a, int pd);
        int outer = ((c >> 8) & 1) * 4 + ((c >> 5) & 3);
        int low   = (((c >> 10) & 1) == 1) ? pd : (a & 15);
        return outer * 131072 + ref_inner(c, a) * 16384 + (a & 16'h3FF0) + low;
    endfunction

    // reference register update
    always @(posedge clk) begin
        if (rst) m_cfg <= 0;
        else if (cpu_wr_stb && cpu_addr[15]) m_cfg <= int'(cpu_addr[10:0]);
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int e;
            e = ref_prg(m_cfg, int'(cpu_addr), int'(pads));
            check("R4 outer bank", int'(prg_addr[19:17]), (e >> 17) & 7);
            check(((m_cfg >> 7) & 1) == 1 ? "R5 nrom inner bank" : "R6 unrom inner bank",
                  int'(prg_addr[16:14]), (e >> 14) & 7);
            check("R4 pass-through", int'(prg_addr[13:4]), (e >> 4) & 10'h3FF);
            check("R7 low nibble", int'(prg_addr[3:0]), e & 15);
            check("R3 mirroring", int'(ciram_a10), ((m_cfg >> 1) & 1) == 1 ? int'(ppu_a11) : int'(ppu_a10));
            check("R8 chr write enable", int'(chr_we),
                  (((m_cfg >> 7) & 1) == 1) ? 0 : int'(ppu_wr_stb));
            check("R10 output enable", int'(prg_oe), int'(cpu_rw && cpu_addr[15]));
        end
    end

    task automatic bus_write(logic [15:0] a);
        cpu_addr = a; cpu_rw = 1'b0; cpu_wr_stb = 1'b1;
        @(posedge clk); #1;
        cpu_wr_stb = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic bus_read(logic [15:0] a, logic [3:0] pd, logic [2:0] pp);
        cpu_addr = a; cpu_rw = 1'b1; pads = pd;
        ppu_a10 = pp[0]; ppu_a11 = pp[1]; ppu_wr_stb = pp[2];
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        cpu_addr = 16'hFFFF; cpu_wr_stb = 1'b1; cpu_rw = 1'b0; // write during reset is lost
        @(posedge clk); #1;
        cpu_wr_stb = 1'b0; cpu_rw = 1'b1;
        rst = 1'b0;
        // R9: both windows on bank 0 after reset
        cpu_addr = 16'h8123; #1;
        check("R9 reset low window", int'(prg_addr[19:14]), 0);
        cpu_addr = 16'hC456; #1;
        check("R9 reset high window", int'(prg_addr[19:14]), 0);
        @(posedge clk); #1;

        // R2: A14 source selection
        bus_write(16'h8084);          // nrom=1, pass=0, p=1
        bus_read(16'h8000, 4'h0, 3'b000);
        check("R2 p drives A14", int'(prg_addr[14]), 1);
        bus_write(16'h8085);          // nrom=1, pass=1, p=1
        bus_read(16'h8000, 4'h0, 3'b000);
        check("R2 cpu A14 low", int'(prg_addr[14]), 0);
        bus_read(16'hC000, 4'h0, 3'b000);
        check("R2 cpu A14 high", int'(prg_addr[14]), 1);

        // R1: strobe below $8000 ignored
        bus_write(16'h8000);
        bus_write(16'h7FFF);
        bus_read(16'hC000, 4'hA, 3'b111);
        check("R1 low write ignored bank", int'(prg_addr[19:14]), 0);
        check("R1 low write ignored pads", int'(prg_addr[3:0]), 0);
        check("R1 low write ignored chr", int'(chr_we), 1);

        // sweep: all S/O/L combinations, banks, mirroring, pad select
        for (int combo = 0; combo < 8; combo++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [15:0] w;
                    w = 16'h8000;
                    w[0] = combo[0]; w[7] = combo[1]; w[9] = combo[2];
                    w[10] = m[0]; w[1] = pat[0];
                    w[4:2] = 3'(pat * 3 + combo);
                    w[6:5] = 2'(pat + 1); w[8] = pat[1];
                    w[14:11] = 4'(combo + pat);   // unlatched bits vary
                    bus_write(w);
                    for (int r = 0; r < 6; r++) begin
                        logic [15:0] a;
                        a = 16'(16'h8000 | ((r * 16'h1A5B + pat * 16'h0313) & 16'h3FFF));
                        a[14] = r[0];
                        bus_read(a, 4'(r * 5 + pat), 3'(r + combo));
                    end
                    bus_read(16'h4321, 4'h3, 3'b100);   // R10 below cart space
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule